// File: doc/BRIEF.md
# Two-Operand Execution Unit with Status Flags

This block performs the arithmetic and logical work of the two-operand instructions in a small 16-bit processor core. Each cycle the decoder presents a 4-bit operation code, a byte/word select, and the source and destination operand values. The unit then produces the result value and a write-back enable, both combinationally. The carry that arithmetic operations consume is taken from the unit's own status register.

Four status bits are held in a register inside the unit: overflow (V), negative (N), zero (Z) and carry (C). Each bit updates on a clock edge where the execute enable is high. Which bits change, and what they mean, depends on the operation. Binary operations report signed overflow and carry. The logic operations report "result nonzero" as carry. XOR reports "both operands negative" as overflow. Moves, bit-set and bit-clear keep every flag. The decimal add keeps overflow and reports a decimal carry. Addressing modes, operand fetch and instruction sequencing belong to the surrounding core.

Top module: `alu2_exec`

## Requirements
- R1: Opcode values are MOV=4, ADD=5, ADDC=6, SUBC=7, SUB=8, CMP=9, DADD=A, BIT=B, BIC=C, BIS=D, XOR=E, AND=F. For opcodes 0 to 3, `illegal` is 1, `wr_en` is 0, `result` is 0, and no flag changes.
- R2: When `byte_sel` is 1, only the low 8 bits of each operand take part, result bits 15:8 are 0, and bit 7 is the sign bit. When `byte_sel` is 0, all 16 bits take part and bit 15 is the sign bit.
- R3: ADD gives dst+src and ADDC gives dst+src+C. Both write back. Both set V when the operands share a sign that the result does not, set N from the result sign, set Z on a zero result, and set C on a carry out of the sign bit.
- R4: SUB gives dst+NOT(src)+1 and SUBC gives dst+NOT(src)+C. Both write back. C=1 means no borrow. V is set when the operands differ in sign and the result sign differs from the destination sign. N and Z follow the result.
- R5: CMP updates V, N, Z and C exactly as SUB would, and keeps `wr_en` at 0.
- R6: AND (which writes back) and BIT (which does not) give src AND dst, clear V, set N from the result sign and Z on a zero result, and set C to NOT Z.
- R7: XOR gives src XOR dst and writes back. N and Z follow the result, C is NOT Z, and V is 1 only when both operands are negative.
- R8: MOV gives src, BIC gives NOT(src) AND dst, and BIS gives src OR dst. All three write back and leave all four flags unchanged.
- R9: DADD adds src, dst and C as packed BCD digits (2 digits for a byte, 4 for a word) and writes back. C is set when the decimal sum exceeds 99 (byte) or 9999 (word). N follows the result sign bit, Z flags a zero result, and V is kept.
- R10: A synchronous active-high `rst` clears all four flags. Flags change only at a rising clock edge where `exec_en` is 1.
- R11: The carry consumed by ADDC, SUBC and DADD is the C flag stored by the previous executed operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| exec_en | input | 1 | Commit the flag update of this cycle's operation |
| opcode | input | 4 | Operation code |
| byte_sel | input | 1 | 1 = byte operation, 0 = word operation |
| src_op | input | 16 | Source operand |
| dst_op | input | 16 | Destination operand |
| result | output | 16 | Operation result (combinational) |
| wr_en | output | 1 | Result should be written to the destination |
| illegal | output | 1 | Opcode is in the unused range 0 to 3 |
| flag_v | output | 1 | Stored overflow flag |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |

## Verification
The hardest case to reach is one that depends on flag history. Carry-consuming operations and the overflow kept by the decimal add cannot be driven from the ports. They only reach the intended state through an earlier executed operation. The bench therefore chains operations in a fixed order: an overflowing ADD sets V ahead of the decimal adds, a borrowing SUB clears C ahead of a SUBC, and a wrapping ADD sets C ahead of an ADDC. Its reference model tracks the expected flags across the whole sequence, so each carry-in is predicted rather than assumed.

// File: rtl/alu2_pkg.sv
package alu2_pkg;

    localparam int DATA_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int DIGITS   = DATA_W / 4;
    localparam int B_DIGITS = BYTE_W / 4;

    typedef enum logic [3:0] {
        OP_MOV  = 4'h4,
        OP_ADD  = 4'h5,
        OP_ADDC = 4'h6,
        OP_SUBC = 4'h7,
        OP_SUB  = 4'h8,
        OP_CMP  = 4'h9,
        OP_DADD = 4'hA,
        OP_BIT  = 4'hB,
        OP_BIC  = 4'hC,
        OP_BIS  = 4'hD,
        OP_XOR  = 4'hE,
        OP_AND  = 4'hF
    } alu_op_e;

    // How an operation treats the status bits
    typedef enum logic [2:0] {
        FK_KEEP,
        FK_ARITH,
        FK_DEC,
        FK_LOGIC,
        FK_XOR
    } flag_kind_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    function automatic logic sign_of(logic [DATA_W-1:0] x, logic narrow);
        return narrow ? x[BYTE_W-1] : x[DATA_W-1];
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(logic [DATA_W-1:0] x, logic narrow);
        return narrow ? {{(DATA_W-BYTE_W){1'b0}}, x[BYTE_W-1:0]} : x;
    endfunction

endpackage

// File: rtl/alu2_bin_add.sv
module alu2_bin_add #(
    parameter int W  = 16,
    parameter int NW = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         narrow,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0]  wide_s;
    logic [NW:0] nar_s;
    logic        sa, sb, sr;

    always_comb begin
        wide_s = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        nar_s  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        if (narrow) begin
            sum  = {{(W-NW){1'b0}}, nar_s[NW-1:0]};
            cout = nar_s[NW];
            sa   = a[NW-1];
            sb   = b[NW-1];
            sr   = nar_s[NW-1];
        end else begin
            sum  = wide_s[W-1:0];
            cout = wide_s[W];
            sa   = a[W-1];
            sb   = b[W-1];
            sr   = wide_s[W-1];
        end
        // b is already inverted for subtraction, so one rule covers both
        ovf = (sa == sb) && (sr != sa);
    end
endmodule

// File: rtl/alu2_bcd_add.sv
module alu2_bcd_add #(
    parameter int ND  = 4,
    parameter int NND = 2
) (
    input  logic [4*ND-1:0] a,
    input  logic [4*ND-1:0] b,
    input  logic            cin,
    input  logic            narrow,
    output logic [4*ND-1:0] sum,
    output logic            cout
);
    logic [ND:0]     cy;
    logic [4*ND-1:0] raw_sum;

    assign cy[0] = cin;

    for (genvar g = 0; g < ND; g++) begin : g_digit
        logic [4:0] raw;
        logic       adj;
        assign raw = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'b0, cy[g]};
        assign adj = raw > 5'd9;
        assign raw_sum[4*g +: 4] = adj ? raw[3:0] + 4'd6 : raw[3:0];
        assign cy[g+1] = adj;
    end

    assign sum  = narrow ? {{(4*(ND-NND)){1'b0}}, raw_sum[4*NND-1:0]} : raw_sum;
    assign cout = narrow ? cy[NND] : cy[ND];
endmodule

// File: rtl/alu2_flag_reg.sv
module alu2_flag_reg
    import alu2_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  flags_t upd,
    input  flags_t nxt,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            if (upd.v) q.v <= nxt.v;
            if (upd.n) q.n <= nxt.n;
            if (upd.z) q.z <= nxt.z;
            if (upd.c) q.c <= nxt.c;
        end
    end

    // R10: reset clears every flag
    a_r10_reset_clears: assert property (@(posedge clk) rst |=> (q == '0));
    // R10: no enable, no change
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));
endmodule

// File: rtl/alu2_exec.sv
module alu2_exec
    import alu2_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        exec_en,
    input  logic [3:0]  opcode,
    input  logic        byte_sel,
    input  logic [15:0] src_op,
    input  logic [15:0] dst_op,
    output logic [15:0] result,
    output logic        wr_en,
    output logic        illegal,
    output logic        flag_v,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_c
);
    alu_op_e          op;
    flags_t           fq, fnxt, fupd;
    flag_kind_e       kind;
    logic [DATA_W-1:0] add_b, add_sum, bcd_sum, raw_res;
    logic              add_cin, add_cout, add_ovf, bcd_cout;
    logic              res_zero, res_neg;

    assign op = alu_op_e'(opcode);

    // operand preparation for the binary adder
    always_comb begin
        add_b   = src_op;
        add_cin = 1'b0;
        unique case (op)
            OP_ADDC:        add_cin = fq.c;
            OP_SUB, OP_CMP: begin add_b = ~src_op; add_cin = 1'b1; end
            OP_SUBC:        begin add_b = ~src_op; add_cin = fq.c; end
            default: ;
        endcase
    end

    alu2_bin_add #(.W(DATA_W), .NW(BYTE_W)) u_add (
        .a(dst_op), .b(add_b), .cin(add_cin), .narrow(byte_sel),
        .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
    );

    alu2_bcd_add #(.ND(DIGITS), .NND(B_DIGITS)) u_bcd (
        .a(dst_op), .b(src_op), .cin(fq.c), .narrow(byte_sel),
        .sum(bcd_sum), .cout(bcd_cout)
    );

    // result selection and write-back decision
    always_comb begin
        raw_res = '0;
        wr_en   = 1'b0;
        illegal = 1'b0;
        kind    = FK_KEEP;
        unique case (op)
            OP_MOV:  begin raw_res = src_op;            wr_en = 1'b1; end
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC:
                     begin raw_res = add_sum;           wr_en = 1'b1; kind = FK_ARITH; end
            OP_CMP:  begin raw_res = add_sum;                         kind = FK_ARITH; end
            OP_DADD: begin raw_res = bcd_sum;           wr_en = 1'b1; kind = FK_DEC;   end
            OP_BIT:  begin raw_res = src_op & dst_op;                 kind = FK_LOGIC; end
            OP_AND:  begin raw_res = src_op & dst_op;   wr_en = 1'b1; kind = FK_LOGIC; end
            OP_BIC:  begin raw_res = ~src_op & dst_op;  wr_en = 1'b1; end
            OP_BIS:  begin raw_res = src_op | dst_op;   wr_en = 1'b1; end
            OP_XOR:  begin raw_res = src_op ^ dst_op;   wr_en = 1'b1; kind = FK_XOR;   end
            default: illegal = 1'b1;
        endcase
    end

    assign result   = width_mask(raw_res, byte_sel);
    assign res_zero = (result == '0);
    assign res_neg  = sign_of(result, byte_sel);

    // flag rules per operation class
    always_comb begin
        fnxt   = '0;
        fupd   = '0;
        fnxt.n = res_neg;
        fnxt.z = res_zero;
        unique case (kind)
            FK_ARITH: begin fupd = 4'b1111; fnxt.v = add_ovf; fnxt.c = add_cout; end
            FK_DEC:   begin fupd = 4'b0111; fnxt.c = bcd_cout; end
            FK_LOGIC: begin fupd = 4'b1111; fnxt.v = 1'b0; fnxt.c = ~res_zero; end
            FK_XOR:   begin
                fupd   = 4'b1111;
                fnxt.v = sign_of(src_op, byte_sel) & sign_of(dst_op, byte_sel);
                fnxt.c = ~res_zero;
            end
            default: ;
        endcase
    end

    alu2_flag_reg u_flags (
        .clk(clk), .rst(rst), .en(exec_en), .upd(fupd), .nxt(fnxt), .q(fq)
    );

    assign flag_v = fq.v;
    assign flag_n = fq.n;
    assign flag_z = fq.z;
    assign flag_c = fq.c;

    // R2: byte results carry nothing above bit 7
    a_r2_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
        byte_sel |-> (result[15:8] == 8'h00));
    // R1: an unused opcode leaves the flags alone
    a_r1_illegal_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (exec_en && opcode < 4'h4) |=> $stable({flag_v, flag_n, flag_z, flag_c}));
    // R8: move, bit-set and bit-clear keep the flags
    a_r8_keep_flags: assert property (@(posedge clk) disable iff (rst)
        (exec_en && (opcode == 4'h4 || opcode == 4'hC || opcode == 4'hD))
        |=> $stable({flag_v, flag_n, flag_z, flag_c}));
    // R6: after AND or BIT, V is clear and C is the inverse of Z
    a_r6_logic_flags: assert property (@(posedge clk) disable iff (rst)
        (exec_en && (opcode == 4'hF || opcode == 4'hB)) |=> (!flag_v && (flag_c != flag_z)));
    // R5: compare never writes
    a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
        (opcode == 4'h9) |-> !wr_en);
    // R9: decimal add keeps V
    a_r9_dec_keeps_v: assert property (@(posedge clk) disable iff (rst)
        (exec_en && opcode == 4'hA) |=> $stable(flag_v));
endmodule

// File: tb/alu2_exec_tb.sv
module alu2_exec_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_en = 1'b0;
    logic [3:0]  opcode = 4'h0;
    logic        byte_sel = 1'b0;
    logic [15:0] src_op = '0;
    logic [15:0] dst_op = '0;
    logic [15:0] result;
    logic        wr_en, illegal, flag_v, flag_n, flag_z, flag_c;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    bit ev = 0, en_ = 0, ez = 0, ec = 0;   // expected flags

    always #4 clk = ~clk;   // 125 MHz

    alu2_exec dut_i (
        .clk(clk), .rst(rst), .exec_en(exec_en), .opcode(opcode), .byte_sel(byte_sel),
        .src_op(src_op), .dst_op(dst_op), .result(result), .wr_en(wr_en),
        .illegal(illegal), .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int sval(input int x, input bit bw);
        if (bw) return (x >= 128) ? x - 256 : x;
        return (x >= 32768) ? x - 65536 : x;
    endfunction

    function automatic int bcd2int(input int x, input bit bw);
        int r = 0;
        for (int i = (bw ? 1 : 3); i >= 0; i--) r = r * 10 + ((x >> (4 * i)) & 15);
        return r;
    endfunction

    function automatic int int2bcd(input int x);
        int r = 0;
        for (int i = 0; i < 4; i++) begin r |= (x % 10) << (4 * i); x /= 10; end
        return r;
    endfunction

    // drive one operation, check combinational outputs, then stored flags
    task automatic run(input int op, input bit bw, input int s, input int d,
                       input bit en, input string tag);
        int mask = bw ? 'hFF : 'hFFFF;
        int sm = s & mask, dm = d & mask;
        int r = 0, sum, tot, lo, hi, lim, cin;
        bit ew = 0, ei = 0, kv = 1, kn = 1, kz = 1, kc = 1;
        bit v = ev, c = ec;
        @(negedge clk);
        opcode = op[3:0]; byte_sel = bw; src_op = s[15:0]; dst_op = d[15:0]; exec_en = en;
        #1;
        lo = bw ? -128 : -32768; hi = bw ? 127 : 32767;
        case (op)
            4, 12, 13: begin
                r = (op == 4) ? sm : (op == 12) ? (~sm & dm & mask) : (sm | dm);
                ew = 1;
            end
            5, 6: begin
                cin = (op == 6) ? int'(ec) : 0;
                sum = dm + sm + cin; r = sum & mask; c = sum > mask;
                tot = sval(dm, bw) + sval(sm, bw) + cin; v = tot > hi || tot < lo;
                ew = 1; kv = 0; kn = 0; kz = 0; kc = 0;
            end
            7, 8, 9: begin
                cin = (op == 7) ? int'(ec) : 1;
                sum = dm + (~sm & mask) + cin; r = sum & mask; c = sum > mask;
                tot = sval(dm, bw) - sval(sm, bw) - 1 + cin; v = tot > hi || tot < lo;
                ew = (op != 9); kv = 0; kn = 0; kz = 0; kc = 0;
            end
            10: begin
                lim = bw ? 100 : 10000;
                tot = bcd2int(dm, bw) + bcd2int(sm, bw) + int'(ec);
                c = tot >= lim; r = int2bcd(tot % lim) & mask;
                ew = 1; kn = 0; kz = 0; kc = 0;
            end
            11, 15: begin
                r = sm & dm; v = 0; c = (r != 0);
                ew = (op == 15); kv = 0; kn = 0; kz = 0; kc = 0;
            end
            14: begin
                r = sm ^ dm; c = (r != 0);
                v = sval(sm, bw) < 0 && sval(dm, bw) < 0;
                ew = 1; kv = 0; kn = 0; kz = 0; kc = 0;
            end
            default: ei = 1;
        endcase
        chk(tag, "result", int'(result), r);
        chk(tag, "wr_en", int'(wr_en), int'(ew));
        chk(tag, "illegal", int'(illegal), int'(ei));
        if (en) begin
            if (!kv) ev = v;
            if (!kn) en_ = bw ? r[7] : r[15];
            if (!kz) ez = (r == 0);
            if (!kc) ec = c;
        end
        @(negedge clk);
        exec_en = 0;
        #1;
        chk(tag, "flags", int'({flag_v, flag_n, flag_z, flag_c}), int'({ev, en_, ez, ec}));
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); #1;
        chk("R10", "flags after reset", int'({flag_v, flag_n, flag_z, flag_c}), 0);
        rst = 0;
        ev = 0; en_ = 0; ez = 0; ec = 0;
    endtask

    task automatic t_add();
        run(5, 0, 'h0001, 'h7FFF, 1, "R3");          // signed overflow, negative
        run(5, 0, 'h0001, 'hFFFF, 1, "R3");          // carry out, zero
        run(6, 0, 'h0001, 'h1234, 1, "R11");         // consumes C=1
        run(5, 1, 'hAB7F, 'hCD01, 1, "R2");          // byte: 7F+01 overflow
        run(6, 1, 'h00FF, 'h0001, 1, "R2");          // byte carry from bit 7
    endtask

    task automatic t_sub();
        run(8, 0, 3, 5, 1, "R4");
        run(8, 0, 5, 3, 1, "R4");                    // borrow, C=0
        run(7, 0, 3, 10, 1, "R11");                  // SUBC with C=0 -> 6
        run(8, 0, 1, 'h8000, 1, "R4");               // overflow
        run(7, 0, 3, 10, 1, "R4");                   // SUBC with C=1 -> 7
        run(8, 1, 1, 'h1200, 1, "R2");               // byte 00-01 = FF
    endtask

    task automatic t_cmp();
        run(9, 0, 'h1234, 'h1234, 1, "R5");
        run(9, 0, 'h0002, 'h8001, 1, "R5");
        run(9, 1, 'h0090, 'h0010, 1, "R5");
    endtask

    task automatic t_logic();
        run(15, 0, 'hF0F0, 'h0F0F, 1, "R6");
        run(11, 0, 'h8000, 'h8001, 1, "R6");
        run(14, 0, 'h8000, 'hFFFF, 1, "R7");         // both negative
        run(14, 1, 'h0080, 'h0001, 1, "R7");
        run(14, 0, 'h5555, 'h5555, 1, "R7");         // zero result
        run(12, 0, 'h00FF, 'h1234, 1, "R8");
        run(13, 0, 'h8001, 'h0100, 1, "R8");
        run(4, 0, 'h0000, 'hBEEF, 1, "R8");
        run(4, 1, 'hBEEF, 'h0000, 1, "R8");
    endtask

    task automatic t_dadd();
        run(5, 0, 'h0001, 'h7FFF, 1, "R9");          // set V, clear C
        run(10, 1, 'h0001, 'h0099, 1, "R9");         // 99+1 -> 00, C
        run(10, 0, 'h5678, 'h1234, 1, "R11");        // +C=1 -> 6913
        run(10, 0, 'h0000, 'h9999, 1, "R9");         // negative sign bit
        run(10, 0, 'h0001, 'h9999, 1, "R9");         // 0000, C
    endtask

    task automatic t_illegal();
        for (int k = 0; k < 4; k++) run(k, 0, 'hFFFF, 'h0001, 1, "R1");
    endtask

    task automatic t_enable();
        run(5, 0, 'h0001, 'hFFFF, 0, "R10");
        run(15, 0, 0, 0, 0, "R10");
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_dadd();
        t_illegal();
        t_enable();
        t_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule